// File: doc/BRIEF.md
# DRAM CBR Refresh and Self-Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive on behalf of a memory controller. A free-running interval counter works out when each CAS-before-RAS refresh is due. The spacing between refreshes is the retention period divided by the number of CBR cycles needed to cover the array. Because the DRAM's internal row counter supplies the row, the block drives only the two strobes and never a row address. Each refresh is first requested from the access sequencer. Once a grant comes back, the block owns the strobes until every outstanding refresh has been issued back to back.

One parameter chooses between the two refresh styles. In the distributed style, one refresh becomes due per interval. In the burst style, the whole row count becomes due at once, once per retention period. The controller can also park the DRAM in self refresh. It does this by asking the block to enter: the block runs a CBR lead-in and then keeps RAS low for as long as self refresh lasts. A later exit command releases RAS and holds both strobes high for the exit recovery count. After that, burst-style operation issues a full catch-up burst, while distributed-style operation simply restarts its interval.

Top module: `ref_sched`

## Requirements
- R1: While rst is high and in the first cycle after it, ras_n and cas_n are 1 and ref_req, busy and sr_active are 0.
- R2: In distributed mode with ref_gnt held high, refresh cycles start exactly INTERVAL clocks apart, where INTERVAL = CLK_KHZ*RETENTION_MS/ROWS.
- R3: Every refresh cycle drives cas_n low for T_CSR clocks while ras_n is high, then holds both low for T_RAS clocks, then holds both high for at least T_RP clocks before cas_n falls again.
- R4: ref_req is high only while the block is idle and has a refresh or a self-refresh entry outstanding. A clock with ref_req and ref_gnt both high makes busy 1 and cas_n 0 in the next clock. ref_gnt while ref_req is low has no effect.
- R5: Refreshes that fall due while no grant arrives are kept in a backlog. The backlog saturates at BACKLOG_MAX in distributed mode and at 2*ROWS in burst mode. One grant issues the whole backlog back to back, one cycle every T_CSR+T_RAS+T_RP clocks, and busy stays high throughout.
- R6: A pulse on sr_enter is remembered and carried out on the next grant: a T_CSR lead-in with cas_n low, then ras_n and cas_n held low with sr_active high. This state lasts until sr_exit has been seen and at least T_RASS clocks have passed. An exit requested early gives a hold of exactly T_RASS clocks.
- R7: After self refresh ends, ras_n and cas_n stay high and busy stays high for T_RPS clocks. sr_exit while not in self refresh and sr_enter while in self refresh are ignored.
- R8: In distributed mode, leaving self refresh clears the backlog and restarts the interval. With ref_gnt high, the next refresh starts INTERVAL+1 clocks after busy falls.
- R9: In burst mode, ROWS refreshes become due together every ROWS*INTERVAL clocks. After self refresh, ROWS back-to-back refreshes follow the T_RPS recovery with no new grant, so busy lasts T_RPS+ROWS*(T_CSR+T_RAS+T_RP) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access sequencer hands the strobes to this block |
| sr_enter | input | 1 | Pulse: request entry into self refresh |
| sr_exit | input | 1 | Pulse: request exit from self refresh |
| ref_req | output | 1 | Block asks the access sequencer for the strobes |
| busy | output | 1 | Block owns the strobes |
| ras_n | output | 1 | Row strobe, active low, during refresh |
| cas_n | output | 1 | Column strobe, active low, during refresh |
| sr_active | output | 1 | DRAM is being held in self refresh |

## Verification
On every clock, the assertions check the strobe ordering (CAS before RAS), the minimum RAS-low and precharge lengths, the request-only-when-idle rule, the one-clock response to a grant, the backlog ceiling and the minimum self-refresh hold. Other behaviours can only be shown by the bench's scenarios: the exact interval and burst period, the count of back-to-back cycles after a missed grant or after self-refresh exit, the exact recovery length, and the commands that must be ignored. It measures these through strobe edge counts and busy lengths.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STROBE,
        ST_PRECH,
        ST_SR_LEAD,
        ST_SR_HOLD,
        ST_SR_EXIT
    } ref_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic strobe_t strobe_of(ref_state_e s);
        strobe_t r;
        r.cas_n = !(s inside {ST_LEAD, ST_STROBE, ST_SR_LEAD, ST_SR_HOLD});
        r.ras_n = !(s inside {ST_STROBE, ST_SR_HOLD});
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_tick.sv
module ref_tick #(
    parameter int INTERVAL   = 1562,
    parameter int ROWS       = 4096,
    parameter int BURST_MODE = 0,
    parameter int ADD_W      = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [ADD_W-1:0] add_amt
);
    localparam int IVL_W = $clog2(INTERVAL);
    localparam int PER_W = $clog2(ROWS);

    logic [IVL_W-1:0] ivl_cnt;
    logic             tick;

    assign tick = (ivl_cnt == IVL_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            ivl_cnt <= '0;
        else if (tick)
            ivl_cnt <= '0;
        else
            ivl_cnt <= ivl_cnt + 1'b1;
    end

    generate
        if (BURST_MODE != 0) begin : g_burst
            logic [PER_W-1:0] per_cnt;
            logic             per_last;
            assign per_last = (per_cnt == PER_W'(ROWS - 1));
            always_ff @(posedge clk) begin
                if (rst || clear)
                    per_cnt <= '0;
                else if (tick)
                    per_cnt <= per_last ? '0 : per_cnt + 1'b1;
            end
            assign add_amt = (tick && per_last) ? ADD_W'(ROWS) : '0;
        end else begin : g_dist
            assign add_amt = tick ? ADD_W'(1) : '0;
        end
    endgenerate

endmodule

// File: rtl/ref_seq.sv
module ref_seq
    import ref_sched_pkg::*;
#(
    parameter int ROWS       = 4096,
    parameter int CAP        = 15,
    parameter int BURST_MODE = 0,
    parameter int T_CSR      = 2,
    parameter int T_RAS      = 6,
    parameter int T_RP       = 4,
    parameter int T_RASS     = 10000,
    parameter int T_RPS      = 11,
    parameter int ADD_W      = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_gnt,
    input  logic             sr_enter,
    input  logic             sr_exit,
    input  logic [ADD_W-1:0] add_amt,
    output logic             ref_req,
    output logic             busy,
    output logic             ras_n,
    output logic             cas_n,
    output logic             sr_active,
    output logic             tick_clear
);
    localparam int PEND_W  = $clog2(CAP + 1);
    localparam int SUM_W   = $clog2(CAP + ROWS + 1) + 1;
    localparam int TMR_MAX = max2(max2(max2(T_CSR, T_RAS), max2(T_RP, T_RASS)), T_RPS);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int HI_W    = $clog2(T_RP + 1);

    ref_state_e        state, state_nx;
    logic [TMR_W-1:0]  tmr, tmr_nx;
    logic [PEND_W-1:0] pending, pend_nx;
    logic              sr_want, exit_want;
    logic              in_sr, take, tmr_done, hold_release, sr_done, chain, start_cbr;
    logic [SUM_W-1:0]  sum, capped;
    strobe_t           strb;

    always_comb begin
        in_sr        = state inside {ST_SR_LEAD, ST_SR_HOLD, ST_SR_EXIT};
        ref_req      = (state == ST_IDLE) && ((pending != '0) || sr_want);
        take         = ref_req && ref_gnt;
        tmr_done     = (tmr == '0);
        hold_release = (state == ST_SR_HOLD) && tmr_done && exit_want;
        sr_done      = (state == ST_SR_EXIT) && tmr_done;
        chain        = (state == ST_PRECH) && tmr_done && (pending != '0);
        start_cbr    = (take && !sr_want) || chain;
        sum          = SUM_W'(pending) + SUM_W'(add_amt);
        capped       = (sum > SUM_W'(CAP)) ? SUM_W'(CAP) : sum;
        if (sr_done && (BURST_MODE != 0))
            pend_nx = PEND_W'(ROWS - 1);
        else if (in_sr || (take && sr_want))
            pend_nx = '0;
        else
            pend_nx = PEND_W'(capped - SUM_W'(start_cbr));
    end

    always_comb begin
        state_nx = state;
        tmr_nx   = tmr;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    state_nx = sr_want ? ST_SR_LEAD : ST_LEAD;
                    tmr_nx   = TMR_W'(T_CSR - 1);
                end
            end
            ST_LEAD, ST_SR_LEAD: begin
                if (tmr_done) begin
                    state_nx = (state == ST_LEAD) ? ST_STROBE : ST_SR_HOLD;
                    tmr_nx   = (state == ST_LEAD) ? TMR_W'(T_RAS - 1) : TMR_W'(T_RASS - 1);
                end else
                    tmr_nx = tmr - 1'b1;
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_nx = ST_PRECH;
                    tmr_nx   = TMR_W'(T_RP - 1);
                end else
                    tmr_nx = tmr - 1'b1;
            end
            ST_PRECH: begin
                if (chain) begin
                    state_nx = ST_LEAD;
                    tmr_nx   = TMR_W'(T_CSR - 1);
                end else if (tmr_done)
                    state_nx = ST_IDLE;
                else
                    tmr_nx = tmr - 1'b1;
            end
            ST_SR_HOLD: begin
                if (hold_release) begin
                    state_nx = ST_SR_EXIT;
                    tmr_nx   = TMR_W'(T_RPS - 1);
                end else if (!tmr_done)
                    tmr_nx = tmr - 1'b1;
            end
            ST_SR_EXIT: begin
                if (sr_done) begin
                    state_nx = (BURST_MODE != 0) ? ST_LEAD : ST_IDLE;
                    tmr_nx   = TMR_W'(T_CSR - 1);
                end else
                    tmr_nx = tmr - 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            pending   <= '0;
            sr_want   <= 1'b0;
            exit_want <= 1'b0;
        end else begin
            state   <= state_nx;
            tmr     <= tmr_nx;
            pending <= pend_nx;
            if (take && sr_want)
                sr_want <= 1'b0;
            else if (sr_enter && !in_sr)
                sr_want <= 1'b1;
            if (hold_release)
                exit_want <= 1'b0;
            else if (sr_exit && (state inside {ST_SR_LEAD, ST_SR_HOLD}))
                exit_want <= 1'b1;
        end
    end

    assign strb       = strobe_of(state);
    assign ras_n      = strb.ras_n;
    assign cas_n      = strb.cas_n;
    assign busy       = (state != ST_IDLE);
    assign sr_active  = (state == ST_SR_HOLD);
    assign tick_clear = in_sr;

    // Run-length trackers for the strobe timing checks
    logic [TMR_W-1:0] ras_lo_run;
    logic [HI_W-1:0]  hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo_run <= '0;
            hi_run     <= HI_W'(T_RP);
        end else begin
            if (ras_n)
                ras_lo_run <= '0;
            else if (ras_lo_run != TMR_W'(TMR_MAX))
                ras_lo_run <= ras_lo_run + 1'b1;
            if (!(ras_n && cas_n))
                hi_run <= '0;
            else if (hi_run != HI_W'(T_RP))
                hi_run <= hi_run + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> ras_n && cas_n && !busy && !ref_req && !sr_active); // R1
    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |-> !cas_n && $past(!cas_n)); // R3
    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (rst) $rose(ras_n) |-> ras_lo_run >= TMR_W'(T_RAS)); // R3
    AST_PRECH_MIN: assert property (@(posedge clk) disable iff (rst) $fell(cas_n) |-> hi_run == HI_W'(T_RP)); // R3
    AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) ref_req |-> !busy && !sr_active); // R4
    AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (rst) ref_req && ref_gnt |=> busy && !cas_n); // R4
    AST_BACKLOG_CAP: assert property (@(posedge clk) disable iff (rst) pending <= PEND_W'(CAP)); // R5
    AST_SR_HOLD_MIN: assert property (@(posedge clk) disable iff (rst) $fell(sr_active) |-> ras_n && ras_lo_run >= TMR_W'(T_RASS)); // R6

endmodule

// File: rtl/ref_sched.sv
module ref_sched #(
    parameter int CLK_KHZ      = 100000,
    parameter int RETENTION_MS = 64,
    parameter int ROWS         = 4096,
    parameter int BURST_MODE   = 0,
    parameter int BACKLOG_MAX  = 15,
    parameter int T_CSR        = 2,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 4,
    parameter int T_RASS       = 10000,
    parameter int T_RPS        = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ref_req,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic sr_active
);
    localparam int INTERVAL = CLK_KHZ * RETENTION_MS / ROWS;
    localparam int CAP      = (BURST_MODE != 0) ? 2 * ROWS : BACKLOG_MAX;
    localparam int ADD_W    = $clog2(ROWS + 1);

    logic [ADD_W-1:0] add_amt;
    logic             tick_clear;

    ref_tick #(
        .INTERVAL  (INTERVAL),
        .ROWS      (ROWS),
        .BURST_MODE(BURST_MODE),
        .ADD_W     (ADD_W)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clear  (tick_clear),
        .add_amt(add_amt)
    );

    ref_seq #(
        .ROWS      (ROWS),
        .CAP       (CAP),
        .BURST_MODE(BURST_MODE),
        .T_CSR     (T_CSR),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP),
        .T_RASS    (T_RASS),
        .T_RPS     (T_RPS),
        .ADD_W     (ADD_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ref_gnt   (ref_gnt),
        .sr_enter  (sr_enter),
        .sr_exit   (sr_exit),
        .add_amt   (add_amt),
        .ref_req   (ref_req),
        .busy      (busy),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .sr_active (sr_active),
        .tick_clear(tick_clear)
    );

endmodule

// File: tb/ref_sched_tb.sv
module ref_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_KHZ  = 5;
    localparam int P_MS   = 64;
    localparam int P_ROWS = 8;
    localparam int P_BL   = 4;
    localparam int T_CSR  = 2;
    localparam int T_RAS  = 3;
    localparam int T_RP   = 2;
    localparam int T_RASS = 10;
    localparam int T_RPS  = 4;

    function automatic int exp_interval();
        return P_KHZ * P_MS / P_ROWS;
    endfunction
    function automatic int exp_cbr_len();
        return T_CSR + T_RAS + T_RP;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt [2];
    logic sre [2];
    logic srx [2];
    logic req [2];
    logic bsy [2];
    logic ras [2];
    logic cas [2];
    logic sra [2];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ref_sched #(.CLK_KHZ(P_KHZ), .RETENTION_MS(P_MS), .ROWS(P_ROWS), .BURST_MODE(0),
        .BACKLOG_MAX(P_BL), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)
    ) u_dut (
        .clk(clk), .rst(rst), .ref_gnt(gnt[0]), .sr_enter(sre[0]), .sr_exit(srx[0]),
        .ref_req(req[0]), .busy(bsy[0]), .ras_n(ras[0]), .cas_n(cas[0]), .sr_active(sra[0])
    );

    ref_sched #(.CLK_KHZ(P_KHZ), .RETENTION_MS(P_MS), .ROWS(P_ROWS), .BURST_MODE(1),
        .BACKLOG_MAX(P_BL), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)
    ) u_dut_bst (
        .clk(clk), .rst(rst), .ref_gnt(gnt[1]), .sr_enter(sre[1]), .sr_exit(srx[1]),
        .ref_req(req[1]), .busy(bsy[1]), .ras_n(ras[1]), .cas_n(cas[1]), .sr_active(sra[1])
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Strobe monitor: per-instance edge counts and run lengths
    int falls [2];
    int gap [2];
    int last_fall [2];
    int lead [2];
    int rlo [2];
    int last_rlo [2];
    int hi [2];
    logic pras [2];
    logic pcas [2];

    always @(negedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                falls[d] = 0; gap[d] = 0; last_fall[d] = 0; lead[d] = 0;
                rlo[d] = 0; last_rlo[d] = 0; hi[d] = 1000; pras[d] = 1'b1; pcas[d] = 1'b1;
            end else begin
                if (pcas[d] && !cas[d]) begin
                    falls[d]++;
                    gap[d] = cyc - last_fall[d];
                    last_fall[d] = cyc;
                    chk(hi[d] >= T_RP, "R3 precharge before CAS fall", hi[d], T_RP);
                end
                if (pras[d] && !ras[d])
                    chk(lead[d] == T_CSR && !cas[d], "R3 CAS lead before RAS fall", lead[d], T_CSR);
                if (!pras[d] && ras[d]) begin
                    last_rlo[d] = rlo[d];
                    chk(rlo[d] == T_RAS || rlo[d] >= T_RASS, "R3 RAS low length", rlo[d], T_RAS);
                end
                lead[d] = (!cas[d] && ras[d]) ? lead[d] + 1 : 0;
                rlo[d]  = !ras[d] ? rlo[d] + 1 : 0;
                hi[d]   = (cas[d] && ras[d]) ? hi[d] + 1 : 0;
                pras[d] = ras[d];
                pcas[d] = cas[d];
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic busy_len(input int d, output int len, output int nf);
        int f0;
        f0 = falls[d];
        len = 0;
        while (bsy[d] && len < 5000) begin
            len++;
            @(negedge clk);
        end
        nf = falls[d] - f0;
    endtask

    initial begin
        int len, nf, t, f0, c0, n;
        void'($urandom(32'd20240611));
        for (int d = 0; d < 2; d++) begin
            gnt[d] = 1'b0; sre[d] = 1'b0; srx[d] = 1'b0;
        end
        step(3);
        for (int d = 0; d < 2; d++)
            chk(ras[d] && cas[d] && !req[d] && !bsy[d] && !sra[d], "R1 reset state", {ras[d], cas[d], req[d], bsy[d], sra[d]}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        chk(ras[0] && cas[0] && !req[0] && !bsy[0] && !sra[0], "R1 first cycle after reset", {ras[0], cas[0], req[0], bsy[0], sra[0]}, 5'b11000);
        gnt[0] = 1'b1; gnt[1] = 1'b1;

        // R9: burst mode, whole row count due once per period
        t = 0;
        while (!bsy[1] && t < 1000) begin t++; @(negedge clk); end
        chk(cyc >= P_ROWS * exp_interval() && cyc <= P_ROWS * exp_interval() + 2, "R9 first burst time", cyc, P_ROWS * exp_interval() + 1);
        busy_len(1, len, nf);
        chk(nf == P_ROWS, "R9 burst count", nf, P_ROWS);
        chk(len == P_ROWS * exp_cbr_len(), "R9 burst busy length", len, P_ROWS * exp_cbr_len());
        chk(gap[1] == exp_cbr_len(), "R5 back-to-back spacing", gap[1], exp_cbr_len());

        // R9: burst-mode self refresh exit followed by catch-up burst
        sre[1] = 1'b1; @(negedge clk); sre[1] = 1'b0;
        t = 0;
        while (!sra[1] && t < 100) begin t++; @(negedge clk); end
        chk(sra[1] && !ras[1] && !cas[1], "R6 burst-mode self refresh entered", {sra[1], ras[1], cas[1]}, 3'b100);
        srx[1] = 1'b1; @(negedge clk); srx[1] = 1'b0;
        while (sra[1] && t < 200) begin t++; @(negedge clk); end
        busy_len(1, len, nf);
        chk(nf == P_ROWS, "R9 catch-up burst count", nf, P_ROWS);
        chk(len == T_RPS + P_ROWS * exp_cbr_len(), "R9 exit recovery plus burst", len, T_RPS + P_ROWS * exp_cbr_len());

        // R2: distributed spacing with grant held high
        chk(gap[0] == exp_interval(), "R2 distributed spacing", gap[0], exp_interval());
        step(2 * exp_interval());
        chk(gap[0] == exp_interval(), "R2 distributed spacing later", gap[0], exp_interval());

        // R5: three missed intervals then one grant
        while (bsy[0]) @(negedge clk);
        gnt[0] = 1'b0;
        t = 0;
        while (!req[0] && t < 200) begin t++; @(negedge clk); end
        step(2 * exp_interval() + 2);
        chk(req[0] && !bsy[0], "R4 request while waiting", {req[0], bsy[0]}, 2'b10);
        gnt[0] = 1'b1; @(negedge clk); gnt[0] = 1'b0;
        chk(bsy[0] && !cas[0], "R4 grant answered next cycle", {bsy[0], cas[0]}, 2'b10);
        busy_len(0, len, nf);
        chk(nf == 3, "R5 backlog of three", nf, 3);
        chk(len == 3 * exp_cbr_len(), "R5 busy over backlog", len, 3 * exp_cbr_len());

        // R4: grant with no request has no effect
        gnt[0] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!bsy[0] && cas[0] && ras[0], "R4 grant without request ignored", {bsy[0], cas[0]}, 2'b01);
        end

        // R5: saturation of the backlog
        gnt[0] = 1'b0;
        while (bsy[0]) @(negedge clk);
        t = 0;
        while (!req[0] && t < 200) begin t++; @(negedge clk); end
        step(6 * exp_interval() + 2);
        gnt[0] = 1'b1; @(negedge clk); gnt[0] = 1'b0;
        busy_len(0, len, nf);
        chk(nf == P_BL, "R5 backlog saturates", nf, P_BL);
        gnt[0] = 1'b1;

        // R6: self refresh with early exit request
        while (bsy[0]) @(negedge clk);
        sre[0] = 1'b1; @(negedge clk); sre[0] = 1'b0;
        t = 0;
        while (!sra[0] && t < 100) begin t++; @(negedge clk); end
        chk(sra[0] && !ras[0] && !cas[0], "R6 self refresh entered", {sra[0], ras[0], cas[0]}, 3'b100);
        srx[0] = 1'b1; @(negedge clk); srx[0] = 1'b0;
        while (sra[0] && t < 200) begin t++; @(negedge clk); end
        @(negedge clk);
        chk(last_rlo[0] == T_RASS, "R6 early exit holds exactly minimum", last_rlo[0], T_RASS);
        while (bsy[0]) @(negedge clk);

        // R7: exit outside self refresh ignored; enter inside ignored
        srx[0] = 1'b1; @(negedge clk); srx[0] = 1'b0;
        chk(!bsy[0] && !sra[0], "R7 stray exit no effect", {bsy[0], sra[0]}, 0);
        sre[0] = 1'b1; @(negedge clk); sre[0] = 1'b0;
        t = 0;
        while (!sra[0] && t < 100) begin t++; @(negedge clk); end
        step(T_RASS + 20);
        chk(sra[0] && !ras[0] && !cas[0], "R7 stale exit not remembered", {sra[0], ras[0], cas[0]}, 3'b100);
        sre[0] = 1'b1; @(negedge clk); sre[0] = 1'b0;
        step(5);
        srx[0] = 1'b1; @(negedge clk); srx[0] = 1'b0;
        while (sra[0] && t < 400) begin t++; @(negedge clk); end
        len = 0;
        while (bsy[0] && len < 100) begin
            chk(ras[0] && cas[0], "R7 strobes high in recovery", {ras[0], cas[0]}, 2'b11);
            len++;
            @(negedge clk);
        end
        chk(len == T_RPS, "R7 recovery length", len, T_RPS);

        // R8: interval restarts after distributed exit (no re-entry either)
        n = 0;
        while (cas[0] && n < 200) begin n++; @(negedge clk); end
        chk(n == exp_interval() + 1, "R8 first refresh after exit", n, exp_interval() + 1);
        chk(!sra[0], "R7 enter during self refresh ignored", sra[0], 0);

        // R2/R5: random grant pattern, all due refreshes eventually issued
        c0 = cyc; f0 = falls[0];
        for (int it = 0; it < 60; it++) begin
            gnt[0] = 1'b0;
            step($urandom_range(60, 0));
            gnt[0] = 1'b1;
            step($urandom_range(30, 1));
        end
        gnt[0] = 1'b1;
        step(200);
        while (bsy[0]) @(negedge clk);
        n = (cyc - c0) / exp_interval();
        t = falls[0] - f0;
        chk(t >= n - 1 && t <= n + 1, "R2 R5 random grants refresh count", t, n);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule